// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

A synchronous controller that turns single-word host reads and writes into strobe sequences for a 32-bit asynchronous DRAM bank. The bank is made of four byte lanes, and each lane has its own column strobe. The host presents a 21-bit word address. The upper 11 bits form the row and the lower 10 bits form the column, and both travel over one shared 11-bit multiplexed address bus. Every write is an early write: write enable goes low one or more cycles before any column strobe falls, so the DRAM never drives the shared data pins during a write.

After an access the controller leaves the row open. A later request to the same row then costs only a column cycle. A request to another row first closes the open row, waits out the precharge time and then opens the new row. Refresh is requested by an external scheduler. The controller closes any open row, raises a grant and runs a column-before-row refresh cycle. Every timing limit is a parameter counted in clock cycles. At 100 MHz the defaults cover the 60 ns speed grade.

The state machine has these states:
- IDLE: row strobe high, no row open.
- ACT: row strobe low, row address held.
- COL: column address driven, write enable set up, column strobes high.
- CAS: column strobes low.
- OPEN: row held open between page accesses.
- PRE: row precharge.
- REF_SU: column strobes low ahead of the row strobe.
- REF_RAS: refresh row pulse.

Its transitions are:
- IDLE→ACT on an accepted request.
- IDLE→REF_SU on a refresh request.
- ACT→COL, COL→CAS, CAS→OPEN, REF_SU→REF_RAS and REF_RAS→PRE when each one's timer expires.
- OPEN→COL on a page hit.
- OPEN→PRE on a miss, a refresh request or row ageing.
- PRE→ACT when a miss is pending, PRE→REF_SU on a refresh request, otherwise PRE→IDLE.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and immediately after it is released, the row strobe, all four column strobes and write enable are high, read valid and refresh grant are low, and ready is high.
- R2: The row address is req_addr[20:10], presented when the row strobe falls. The column address is req_addr[9:0], zero-extended onto the 11-bit bus, presented when the column strobes fall.
- R3: On a write, column strobe lane i (bits 8i+7:8i, lane 0 lowest) falls only when byte enable bit i is set. Unselected bytes in the DRAM keep their old value, and data is driven only while write enable is low.
- R4: On every write, write enable is low for at least one cycle before the column strobes fall.
- R5: A read drops all four column strobes. It returns the stored word on rd_data with a one-cycle rd_valid pulse in the cycle after the strobes rise.
- R6: A request whose row equals the open row runs without a new falling edge on the row strobe.
- R7: A request to a different row closes the open row, holds the row strobe high for at least max(T_RP, T_RC−T_RAS) cycles, then opens the new row.
- R8: Every row strobe low pulse lasts at least T_RAS cycles and at most RAS_MAX_CYC cycles.
- R9: On a refresh request the controller closes any open row and asserts ref_gnt. It drops the column strobes before the row strobe with write enable high, stores no data, and afterwards reopens rows on demand.
- R10: Ready is low whenever a column strobe is low or a refresh is granted.
- R11: An open row left idle is closed by the controller itself before the row strobe low time exceeds RAS_MAX_CYC.
- R12: Column strobes stay low for at least T_CAS cycles per access. They stay high for at least T_CP cycles between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address, row in 20:10, column in 9:0 |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i for bits 8i+7:8i |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| ref_req | input | 1 | Refresh request from the scheduler |
| ref_gnt | output | 1 | Refresh in progress |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 11 | Multiplexed row and column address |
| dram_dq_out | output | 32 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 32 | Data returned by the DRAM |

## Verification
The bench uses several kinds of traffic. Same-row sequences show whether page hits reuse the open row, which is measured by counting falling edges of the row strobe. Partial-byte writes with alternating and single-lane enables followed by readback show that each lane's strobe is mapped to the right bits. Alternating between rows 5 and 2047 separates the miss path from the hit path. Refresh is requested both with a row open and from idle, and a long idle gap tests the self-closing of an aged row. Throughout, a behavioural DRAM model measures strobe pulse widths and catches late write enables.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_CAS,
        ST_OPEN,
        ST_PRE,
        ST_REF_SU,
        ST_REF_RAS
    } fpm_state_e;

    function automatic int fpm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_cycle_timer.sv
module fpm_cycle_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpm_ras_age.sv
module fpm_ras_age #(
    parameter int MIN_CYC = 6,
    parameter int MAX_CYC = 20000,
    parameter int GUARD   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic min_met,
    output logic near_max
);
    localparam int AW = $clog2(MAX_CYC + 1);

    logic [AW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!ras_low)
            cnt <= '0;
        else if (cnt != AW'(MAX_CYC))
            cnt <= cnt + 1'b1;
    end

    assign min_met  = (cnt >= AW'(MIN_CYC - 1));
    assign near_max = (cnt >= AW'(MAX_CYC - GUARD));
endmodule

// File: rtl/fpm_addr_mux.sv
module fpm_addr_mux #(
    parameter int ROW_W = 11,
    parameter int COL_W = 10
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             sel_col,
    output logic [ROW_W-1:0] addr
);
    assign addr = sel_col ? ROW_W'(col) : row;
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_dram_pkg::*;
#(
    parameter int ROW_W       = 11,
    parameter int COL_W       = 10,
    parameter int DATA_W      = 32,
    parameter int T_RP        = 4,
    parameter int T_RC        = 11,
    parameter int T_RAS       = 6,
    parameter int T_RCD       = 2,
    parameter int T_RAH       = 1,
    parameter int T_CAS       = 2,
    parameter int T_CAC       = 2,
    parameter int T_CP        = 1,
    parameter int T_CSR       = 1,
    parameter int RAS_MAX_CYC = 20000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_be,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   ref_req,
    output logic                   ref_gnt,
    output logic                   dram_ras_n,
    output logic [DATA_W/8-1:0]    dram_cas_n,
    output logic                   dram_we_n,
    output logic [ROW_W-1:0]       dram_addr,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int LANES  = DATA_W / 8;
    localparam int T_PRE  = fpm_max(T_RP, T_RC - T_RAS);
    localparam int T_CASL = fpm_max(T_CAS, T_CAC + 1);
    localparam int T_COLM = fpm_max(T_RCD - T_RAH, T_CP);
    localparam int GUARD  = T_CASL + T_CP + 3;
    localparam int TMAX   = fpm_max(fpm_max(T_PRE, T_RAS), fpm_max(T_CASL, fpm_max(T_COLM, T_CSR)));
    localparam int TW     = $clog2(TMAX + 1);

    fpm_state_e        state, nxt;
    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;
    logic              ras_min, age_close, sel_col, accept, hit, pend;
    logic              cur_we;
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [LANES-1:0]  cur_be;

    fpm_cycle_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    fpm_ras_age #(.MIN_CYC(T_RAS), .MAX_CYC(RAS_MAX_CYC), .GUARD(GUARD)) u_age (
        .clk(clk), .rst_n(rst_n), .ras_low(!dram_ras_n), .min_met(ras_min), .near_max(age_close)
    );

    fpm_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
        .row(cur_row), .col(cur_col), .sel_col(sel_col), .addr(dram_addr)
    );

    assign hit    = (req_addr[ADDR_W-1:COL_W] == cur_row);
    assign accept = req_valid && req_ready;

    // Next state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (ref_req) begin
                    nxt = ST_REF_SU; tmr_load = 1'b1; tmr_val = TW'(T_CSR - 1);
                end else if (req_valid) begin
                    nxt = ST_ACT; tmr_load = 1'b1; tmr_val = TW'(T_RAH - 1);
                end
            end
            ST_ACT: if (tmr_done) begin
                nxt = ST_COL; tmr_load = 1'b1; tmr_val = TW'(T_COLM - 1);
            end
            ST_COL: if (tmr_done) begin
                nxt = ST_CAS; tmr_load = 1'b1; tmr_val = TW'(T_CASL - 1);
            end
            ST_CAS: if (tmr_done) nxt = ST_OPEN;
            ST_OPEN: begin
                if (ras_min) begin
                    if (ref_req || age_close || (req_valid && !hit)) begin
                        nxt = ST_PRE; tmr_load = 1'b1; tmr_val = TW'(T_PRE - 1);
                    end else if (req_valid) begin
                        nxt = ST_COL; tmr_load = 1'b1; tmr_val = TW'(T_CP - 1);
                    end
                end
            end
            ST_PRE: if (tmr_done) begin
                if (pend) begin
                    nxt = ST_ACT; tmr_load = 1'b1; tmr_val = TW'(T_RAH - 1);
                end else if (ref_req) begin
                    nxt = ST_REF_SU; tmr_load = 1'b1; tmr_val = TW'(T_CSR - 1);
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_REF_SU: if (tmr_done) begin
                nxt = ST_REF_RAS; tmr_load = 1'b1; tmr_val = TW'(T_RAS - 1);
            end
            ST_REF_RAS: if (tmr_done) begin
                nxt = ST_PRE; tmr_load = 1'b1; tmr_val = TW'(T_PRE - 1);
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Request latch, pending miss and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_we      <= 1'b0;
            cur_row     <= '0;
            cur_col     <= '0;
            cur_be      <= '0;
            dram_dq_out <= '0;
            pend        <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
        end else begin
            if (accept) begin
                cur_we      <= req_we;
                cur_row     <= req_addr[ADDR_W-1:COL_W];
                cur_col     <= req_addr[COL_W-1:0];
                cur_be      <= req_be;
                dram_dq_out <= req_wdata;
            end
            if (accept && state == ST_OPEN && !hit)
                pend <= 1'b1;
            else if (state == ST_PRE && tmr_done)
                pend <= 1'b0;
            rd_valid <= (state == ST_CAS) && tmr_done && !cur_we;
            if ((state == ST_CAS) && tmr_done && !cur_we)
                rd_data <= dram_dq_in;
        end
    end

    // Outputs decoded from state
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = '1;
        dram_we_n  = 1'b1;
        dram_dq_oe = 1'b0;
        sel_col    = 1'b0;
        ref_gnt    = 1'b0;
        req_ready  = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = !ref_req;
            ST_ACT:     dram_ras_n = 1'b0;
            ST_COL: begin
                dram_ras_n = 1'b0; sel_col = 1'b1;
                dram_we_n  = !cur_we; dram_dq_oe = cur_we;
            end
            ST_CAS: begin
                dram_ras_n = 1'b0; sel_col = 1'b1;
                dram_we_n  = !cur_we; dram_dq_oe = cur_we;
                dram_cas_n = cur_we ? ~cur_be : '0;
            end
            ST_OPEN: begin
                dram_ras_n = 1'b0; sel_col = 1'b1;
                req_ready  = ras_min && !ref_req && !age_close;
            end
            ST_PRE:     ;
            ST_REF_SU: begin
                dram_cas_n = '0; ref_gnt = 1'b1;
            end
            ST_REF_RAS: begin
                dram_ras_n = 1'b0; dram_cas_n = '0; ref_gnt = 1'b1;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk
    import fpm_dram_pkg::*;
#(
    parameter int T_RP        = 4,
    parameter int T_RC        = 11,
    parameter int T_RAS       = 6,
    parameter int T_CAS       = 2,
    parameter int T_CP        = 1,
    parameter int RAS_MAX_CYC = 20000,
    parameter int LANES       = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             ref_gnt,
    input logic             dram_ras_n,
    input logic [LANES-1:0] dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_dq_oe
);
    localparam int T_PRE = fpm_max(T_RP, T_RC - T_RAS);

    logic cas_hi;
    int   ras_lo_cnt, ras_hi_cnt, cas_lo_cnt, cas_hi_cnt;

    assign cas_hi = &dram_cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_cnt <= 0;
            ras_hi_cnt <= T_PRE;
            cas_lo_cnt <= 0;
            cas_hi_cnt <= T_CP;
        end else begin
            ras_lo_cnt <= dram_ras_n ? 0 : ras_lo_cnt + 1;
            ras_hi_cnt <= dram_ras_n ? ((ras_hi_cnt < 1000) ? ras_hi_cnt + 1 : ras_hi_cnt) : 0;
            cas_lo_cnt <= cas_hi ? 0 : cas_lo_cnt + 1;
            cas_hi_cnt <= cas_hi ? ((cas_hi_cnt < 1000) ? cas_hi_cnt + 1 : cas_hi_cnt) : 0;
        end
    end

    // R8
    ras_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> ras_lo_cnt >= T_RAS);
    // R8
    ras_max_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> ras_lo_cnt < RAS_MAX_CYC);
    // R7
    ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> ras_hi_cnt >= T_PRE);
    // R12
    cas_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_hi) |-> cas_lo_cnt >= T_CAS);
    // R12
    cas_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_hi) |-> cas_hi_cnt >= T_CP);
    // R4
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_hi) && !dram_ras_n && !dram_we_n) |-> $past(!dram_we_n));
    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_hi || ref_gnt) |-> !req_ready);
    // R9
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && ref_gnt) |-> (!cas_hi && dram_we_n));
    // R5
    rd_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!cas_hi));
    // R3
    drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> !dram_we_n);
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
    .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_CP(T_CP),
    .RAS_MAX_CYC(RAS_MAX_CYC), .LANES(LANES)
) u_chk (.*);

// File: tb/tb_fpm_dram_ctrl.sv
module tb_fpm_dram_ctrl;
    localparam int RMAX = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready, rd_valid, ref_gnt, dram_ras_n, dram_we_n, dram_dq_oe;
    logic [31:0] rd_data, dram_dq_out;
    logic [31:0] dram_dq_in = '0;
    logic [3:0]  dram_cas_n;
    logic [10:0] dram_addr;

    int checks = 0, failures = 0;

    fpm_dram_ctrl #(.RAS_MAX_CYC(RMAX)) dut (.*);

    always #10 clk = ~clk;

    // ---------------- behavioural DRAM model -----------------
    logic [31:0] mem  [logic [20:0]];
    logic [31:0] shad [logic [20:0]];
    logic [10:0] m_row = '0;
    logic [9:0]  m_col = '0;
    logic        p_ras = 1'b1, p_we = 1'b1;
    logic [3:0]  p_cas = 4'hF;
    int ras_falls = 0, refreshes = 0, late_we = 0;
    int ras_run = 0, cas_run = 0, ras_min_run = 1000, ras_max_run = 0, cas_min_run = 1000;

    always @(negedge clk) begin
        if (p_ras && !dram_ras_n) begin
            if (&dram_cas_n) begin m_row = dram_addr; ras_falls++; end
            else refreshes++;
        end
        if (!dram_ras_n && (&p_cas) && !(&dram_cas_n)) begin
            logic [31:0] w;
            m_col = dram_addr[9:0];
            if (!dram_we_n) begin
                if (p_we) late_we++;
                w = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 32'h0;
                for (int i = 0; i < 4; i++)
                    if (!dram_cas_n[i]) w[8*i +: 8] = dram_dq_out[8*i +: 8];
                mem[{m_row, m_col}] = w;
            end else begin
                dram_dq_in = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 32'h0;
            end
        end
        if (!dram_ras_n) ras_run++;
        else if (!p_ras) begin
            if (ras_run < ras_min_run) ras_min_run = ras_run;
            if (ras_run > ras_max_run) ras_max_run = ras_run;
            ras_run = 0;
        end
        if (!(&dram_cas_n)) cas_run++;
        else if (!(&p_cas)) begin
            if (cas_run < cas_min_run) cas_min_run = cas_run;
            cas_run = 0;
        end
        p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
    end

    // ---------------- scoreboard -----------------
    logic [31:0] exp_q[$];
    int rd_seen = 0, rd_issued = 0;

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            logic [31:0] e;
            rd_seen++;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R5 unexpected read data act=%h exp=none", rd_data);
            end else begin
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    failures++;
                    $display("FAIL R5 read data act=%h exp=%h", rd_data, e);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic [20:0] a, input logic [31:0] d, input logic [3:0] be);
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        if (we) begin
            logic [31:0] w;
            w = shad.exists(a) ? shad[a] : 32'h0;
            for (int i = 0; i < 4; i++) if (be[i]) w[8*i +: 8] = d[8*i +: 8];
            shad[a] = w;
        end else begin
            exp_q.push_back(shad[a]);
            rd_issued++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do begin @(negedge clk); #1; end while (!(req_ready && exp_q.size() == 0));
    endtask

    localparam logic [20:0] A0 = {11'd5, 10'd3};
    localparam logic [20:0] A1 = {11'd5, 10'd1023};
    localparam logic [20:0] B0 = {11'h7FF, 10'd0};

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 ras_n", dram_ras_n, 1); chk("R1 cas_n", dram_cas_n, 4'hF);
        chk("R1 we_n", dram_we_n, 1);   chk("R1 rd_valid", rd_valid, 0);
        chk("R1 ref_gnt", ref_gnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);

        do_req(1, A0, 32'h11223344, 4'hF);
        wait_idle();
        chk("R2 row", m_row, 11'd5); chk("R2 col", m_col, 10'd3);

        f0 = ras_falls;
        do_req(1, A1, 32'hAABBCCDD, 4'hF);
        wait_idle();
        chk("R2 col high", m_col, 10'd1023);
        do_req(0, A0, 0, 0);
        do_req(0, A1, 0, 0);
        wait_idle();
        chk("R6 no new row open on hits", ras_falls - f0, 0);

        do_req(1, A0, 32'h99887766, 4'b0101);
        do_req(0, A0, 0, 0);
        wait_idle();
        chk("R3 lanes 0 and 2", mem[A0], 32'h11883366);
        do_req(1, A0, 32'h5A000000, 4'b1000);
        do_req(0, A0, 0, 0);
        wait_idle();
        chk("R3 lane 3 only", mem[A0], 32'h5A883366);

        f0 = ras_falls;
        do_req(1, B0, 32'hCAFEF00D, 4'hF);
        wait_idle();
        chk("R7 miss opens row", ras_falls - f0, 1);
        chk("R2 row top", m_row, 11'h7FF);
        do_req(0, B0, 0, 0);
        do_req(0, A0, 0, 0);
        wait_idle();
        chk("R7 miss back", ras_falls - f0, 2);
        chk("R4 late write enables", late_we, 0);

        // refresh with row 5 open
        f0 = ras_falls;
        @(negedge clk); ref_req = 1'b1;
        do @(negedge clk); while (!ref_gnt);
        chk("R10 ready low during refresh", req_ready, 0);
        chk("R9 ras high before refresh pulse", dram_ras_n, 1);
        ref_req = 1'b0;
        do_req(0, A1, 0, 0);
        wait_idle();
        chk("R9 refresh count", refreshes, 1);
        chk("R9 row reopened", ras_falls - f0, 1);

        repeat (RMAX + 30) @(negedge clk);
        chk("R11 aged row closed", dram_ras_n, 1);

        ref_req = 1'b1;
        do @(negedge clk); while (!ref_gnt);
        ref_req = 1'b0;
        do_req(0, A1, 0, 0);
        do_req(0, B0, 0, 0);
        wait_idle();
        chk("R9 refresh from idle", refreshes, 2);

        chk("R8 min ras low", (ras_min_run >= 6), 1);
        chk("R8 max ras low", (ras_max_run <= RMAX), 1);
        chk("R12 min cas low", (cas_min_run >= 2), 1);
        chk("R5 read pulses", rd_seen, rd_issued);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule